// File: doc/BRIEF.md
# Compact 16-bit Varint Codec

This block converts between a 16-bit unsigned number and a short byte sequence of one, two or three bytes. Each byte carries a group of seven value bits, the lowest group first. Bit 7 of a byte is set when a further byte follows. The third byte is the end of every sequence. It holds only value bits 15:14 in its bits 1:0, and it never carries a continuation bit. Small values therefore cost one byte, and no value needs more than three.

The encoder side takes a value through a valid/ready handshake. It then sends the bytes one per cycle on a valid/ready output, and marks the final byte with a last flag. The decoder side takes one byte per cycle whenever its input valid is high and is always ready. When a sequence ends it gives a one-cycle result with the rebuilt value. Malformed or non-minimal sequences are reported as errors. The two sides share clock and reset but are otherwise independent, so a link can use either or both.

Top module: `varint16_codec`

## Requirements
- R1: A value up to 0x7F is encoded as one byte, equal to the value with bit 7 clear (0x0000 gives 00, 0x007F gives 7F).
- R2: A value from 0x80 to 0x3FFF is encoded as two bytes. The first byte is value bits 6:0 with bit 7 set. The second byte is bits 13:7 with bit 7 clear (0x0080 gives 80 01, 0x3FFF gives FF 7F).
- R3: A value of 0x4000 or above is encoded as three bytes. The first two bytes are the 7-bit groups, each with bit 7 set. The third byte holds bits 15:14 in bits 1:0, with bits 7:2 zero (0x4000 gives 80 80 01, 0xC000 gives 80 80 03, 0xFFFF gives FF FF 03).
- R4: `enc_out_last` is high exactly on the final byte of a value. Every byte before the final one has bit 7 set, and the final byte has bit 7 clear.
- R5: `enc_in_ready` is high while the encoder is idle, and a value is taken on a cycle with valid and ready both high. Ready is low from the next cycle until the cycle after the final byte is accepted. The first byte is valid in the cycle after the value is taken. A value offered while ready is low is ignored.
- R6: While `enc_out_valid` is high and `enc_out_ready` is low, the output byte and last flag hold their values.
- R7: The decoder assembles groups lowest first. It raises `dec_out_valid` for one cycle, in the cycle after the final byte of a sequence is taken, with the rebuilt value. No result appears after a byte that has bit 7 set at the first or second position.
- R8: A third byte with any of bits 7:2 set ends the sequence with `dec_out_valid` and `dec_out_error` high and `dec_out_value` equal to 0.
- R9: A non-minimal sequence ends with an error and value 0. This means a second byte of 00 that follows a continuation, or a third byte whose bits 1:0 are zero.
- R10: After a result or an error, the next byte starts a new sequence at the first position.
- R11: After reset, `enc_in_ready` is 1, `enc_out_valid` is 0 and `dec_out_valid` is 0, and the decoder waits for a first byte even if reset came in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Value offered to the encoder |
| enc_in_value | input | 16 | Value to encode |
| enc_in_ready | output | 1 | Encoder can take a value |
| enc_out_valid | output | 1 | Encoded byte present |
| enc_out_byte | output | 8 | Encoded byte |
| enc_out_last | output | 1 | Byte is the final one of its value |
| enc_out_ready | input | 1 | Downstream takes the byte |
| dec_in_valid | input | 1 | Byte presented to the decoder |
| dec_in_byte | input | 8 | Byte to decode |
| dec_out_valid | output | 1 | One-cycle result strobe |
| dec_out_value | output | 16 | Rebuilt value, 0 on error |
| dec_out_error | output | 1 | Sequence was malformed or non-minimal |

## Verification
The encoder's first byte is due one cycle after the edge that takes the value. Each later byte is due one cycle after the handshake of the byte before it, and ready returns one cycle after the final handshake. The decoder's result is due one cycle after the edge that takes the final byte. The bench drives inputs on falling edges and samples outputs on the next falling edge, half a cycle after the edge that updates the registers. It checks that no result appears between bytes, and that the stalled byte stays unchanged on each stalled cycle.

// File: rtl/vint16_pkg.sv
package vint16_pkg;

    localparam int VAL_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int GRP_W     = BYTE_W - 1;
    localparam int MAX_BYTES = (VAL_W + GRP_W - 1) / GRP_W;
    localparam int TOP_W     = VAL_W - 2 * GRP_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        POS_LOW = 2'd0,
        POS_MID = 2'd1,
        POS_TOP = 2'd2
    } pos_e;

    typedef struct packed {
        logic valid;
        logic err;
        val_t value;
    } dec_res_t;

    // number of bytes a value needs
    function automatic cnt_t enc_count(input val_t v);
        if (v[VAL_W-1 -: TOP_W] != '0)
            return cnt_t'(3);
        else if (v[2*GRP_W-1 -: GRP_W] != '0)
            return cnt_t'(2);
        else
            return cnt_t'(1);
    endfunction

    // byte at position idx; more sets the continuation flag
    function automatic byte_t enc_byte(input val_t v, input cnt_t idx, input logic more);
        case (idx)
            cnt_t'(0): return {more, v[GRP_W-1:0]};
            cnt_t'(1): return {more, v[2*GRP_W-1 -: GRP_W]};
            default:   return {{(BYTE_W-TOP_W){1'b0}}, v[VAL_W-1 -: TOP_W]};
        endcase
    endfunction

endpackage

// File: rtl/vint16_enc.sv
module vint16_enc
    import vint16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  val_t  in_value,
    output logic  in_ready,
    output logic  out_valid,
    output byte_t out_byte,
    output logic  out_last,
    input  logic  out_ready
);

    val_t val_q;
    logic busy_q;
    cnt_t idx_q;
    cnt_t cnt_q;

    assign in_ready  = !busy_q;
    assign out_valid = busy_q;
    assign out_last  = busy_q && (idx_q == cnt_q - cnt_t'(1));
    assign out_byte  = enc_byte(val_q, idx_q, !out_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            cnt_q  <= cnt_t'(1);
            val_q  <= '0;
        end else if (!busy_q && in_valid) begin
            val_q  <= in_value;
            cnt_q  <= enc_count(in_value);
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && out_ready) begin
            if (out_last)
                busy_q <= 1'b0;
            else
                idx_q <= idx_q + cnt_t'(1);
        end
    end

endmodule

// File: rtl/vint16_dec.sv
module vint16_dec
    import vint16_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  byte_t in_byte,
    output logic  out_valid,
    output val_t  out_value,
    output logic  out_error
);

    pos_e     pos_q, pos_n;
    val_t     acc_q, acc_n;
    logic     fin, bad;
    dec_res_t res_q;

    always_comb begin
        pos_n = pos_q;
        acc_n = acc_q;
        fin   = 1'b0;
        bad   = 1'b0;
        case (pos_q)
            POS_LOW: begin
                acc_n = {{(VAL_W-GRP_W){1'b0}}, in_byte[GRP_W-1:0]};
                if (in_byte[BYTE_W-1]) pos_n = POS_MID;
                else                   fin   = 1'b1;
            end
            POS_MID: begin
                acc_n = {{TOP_W{1'b0}}, in_byte[GRP_W-1:0], acc_q[GRP_W-1:0]};
                if (in_byte[BYTE_W-1]) begin
                    pos_n = POS_TOP;
                end else begin
                    fin = 1'b1;
                    bad = (in_byte[GRP_W-1:0] == '0);
                end
            end
            default: begin
                acc_n = {in_byte[TOP_W-1:0], acc_q[2*GRP_W-1:0]};
                fin   = 1'b1;
                bad   = (in_byte[BYTE_W-1:TOP_W] != '0) || (in_byte[TOP_W-1:0] == '0);
            end
        endcase
        if (fin) pos_n = POS_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_LOW;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            res_q.valid <= in_valid && fin;
            res_q.err   <= in_valid && fin && bad;
            res_q.value <= (in_valid && fin && !bad) ? acc_n : '0;
            if (in_valid) begin
                pos_q <= pos_n;
                acc_q <= acc_n;
            end
        end
    end

    assign out_valid = res_q.valid;
    assign out_value = res_q.value;
    assign out_error = res_q.err;

endmodule

// File: rtl/varint16_codec.sv
module varint16_codec
    import vint16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enc_in_valid,
    input  logic [15:0] enc_in_value,
    output logic        enc_in_ready,
    output logic        enc_out_valid,
    output logic [7:0]  enc_out_byte,
    output logic        enc_out_last,
    input  logic        enc_out_ready,
    input  logic        dec_in_valid,
    input  logic [7:0]  dec_in_byte,
    output logic        dec_out_valid,
    output logic [15:0] dec_out_value,
    output logic        dec_out_error
);

    vint16_enc u_enc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (enc_in_valid),
        .in_value  (enc_in_value),
        .in_ready  (enc_in_ready),
        .out_valid (enc_out_valid),
        .out_byte  (enc_out_byte),
        .out_last  (enc_out_last),
        .out_ready (enc_out_ready)
    );

    vint16_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dec_in_valid),
        .in_byte   (dec_in_byte),
        .out_valid (dec_out_valid),
        .out_value (dec_out_value),
        .out_error (dec_out_error)
    );

endmodule

// File: rtl/varint16_codec_chk.sv
module varint16_codec_chk (
    input logic        clk,
    input logic        rst,
    input logic        enc_in_valid,
    input logic        enc_in_ready,
    input logic        enc_out_valid,
    input logic [7:0]  enc_out_byte,
    input logic        enc_out_last,
    input logic        enc_out_ready,
    input logic        dec_in_valid,
    input logic        dec_out_valid,
    input logic [15:0] dec_out_value,
    input logic        dec_out_error
);

    p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (enc_in_valid && enc_in_ready) |=> (enc_out_valid && !enc_in_ready));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (enc_out_valid && !enc_out_ready) |=>
            (enc_out_valid && $stable(enc_out_byte) && $stable(enc_out_last)));

    p_cont_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (enc_out_valid && !enc_out_last) |-> enc_out_byte[7]);

    p_final_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (enc_out_valid && enc_out_last) |-> !enc_out_byte[7]);

    p_top_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (enc_out_valid && enc_out_last && $past(enc_out_valid && !enc_out_last && enc_out_ready)
         && $past(enc_out_byte[7], 2) && $past(enc_out_valid, 2) && !$past(rst, 2))
            |-> (enc_out_byte[7:2] == 6'd0));

    p_result_cause_r7: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid |-> $past(dec_in_valid));

    p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
        dec_out_error |-> (dec_out_valid && dec_out_value == 16'd0));

endmodule

bind varint16_codec varint16_codec_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .enc_in_valid  (enc_in_valid),
    .enc_in_ready  (enc_in_ready),
    .enc_out_valid (enc_out_valid),
    .enc_out_byte  (enc_out_byte),
    .enc_out_last  (enc_out_last),
    .enc_out_ready (enc_out_ready),
    .dec_in_valid  (dec_in_valid),
    .dec_out_valid (dec_out_valid),
    .dec_out_value (dec_out_value),
    .dec_out_error (dec_out_error)
);

// File: tb/varint16_codec_tb.sv
module varint16_codec_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_in_valid = 1'b0;
    logic [15:0] enc_in_value = '0;
    logic        enc_in_ready;
    logic        enc_out_valid;
    logic [7:0]  enc_out_byte;
    logic        enc_out_last;
    logic        enc_out_ready = 1'b1;
    logic        dec_in_valid = 1'b0;
    logic [7:0]  dec_in_byte = '0;
    logic        dec_out_valid;
    logic [15:0] dec_out_value;
    logic        dec_out_error;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    varint16_codec u_dut (.*);

    // {value, byte count, byte0, byte1, byte2}
    localparam int NV = 10;
    localparam logic [47:0] VEC [NV] = '{
        {16'h0000, 8'd1, 8'h00, 8'h00, 8'h00},
        {16'h0001, 8'd1, 8'h01, 8'h00, 8'h00},
        {16'h007F, 8'd1, 8'h7F, 8'h00, 8'h00},
        {16'h0080, 8'd2, 8'h80, 8'h01, 8'h00},
        {16'h1234, 8'd2, 8'hB4, 8'h24, 8'h00},
        {16'h3FFF, 8'd2, 8'hFF, 8'h7F, 8'h00},
        {16'h4000, 8'd3, 8'h80, 8'h80, 8'h01},
        {16'hC000, 8'd3, 8'h80, 8'h80, 8'h03},
        {16'hABCD, 8'd3, 8'hCD, 8'hD7, 8'h02},
        {16'hFFFF, 8'd3, 8'hFF, 8'hFF, 8'h03}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                chk(1'b0, "watchdog", cycles, 100000);
                finish_run();
            end
        end
    end

    function automatic string len_req(input int n);
        return (n == 1) ? "R1" : (n == 2) ? "R2" : "R3";
    endfunction

    task automatic enc_run(input logic [47:0] v, input bit stall);
        logic [7:0] b;
        int n;
        n = int'(v[31:24]);
        @(negedge clk);
        chk(enc_in_ready, "R5 idle ready", enc_in_ready, 1);
        enc_in_valid = 1'b1;
        enc_in_value = v[47:32];
        @(negedge clk);
        enc_in_valid = 1'b0;
        chk(!enc_in_ready, "R5 busy ready", enc_in_ready, 0);
        for (int i = 0; i < n; i++) begin
            b = v[23 - 8*i -: 8];
            chk(enc_out_valid && enc_out_byte == b, len_req(n), enc_out_byte, b);
            chk(enc_out_last == (i == n-1), "R4 last", enc_out_last, (i == n-1));
            if (stall && i == 0) begin
                enc_out_ready = 1'b0;
                enc_in_valid  = 1'b1;
                enc_in_value  = 16'h0042;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    chk(enc_out_valid && enc_out_byte == b, "R6 hold byte", enc_out_byte, b);
                    chk(!enc_in_ready, "R5 ignore while busy", enc_in_ready, 0);
                end
                enc_in_valid  = 1'b0;
                enc_out_ready = 1'b1;
            end
            @(negedge clk);
        end
        chk(enc_in_ready && !enc_out_valid, "R5 ready back", enc_in_ready, 1);
        #1;
    endtask

    task automatic dec_run(input logic [23:0] bytes, input int n,
                           input bit exp_err, input logic [15:0] exp_val, input string req);
        for (int i = 0; i < n; i++) begin
            if (i == 0) @(negedge clk);
            dec_in_valid = 1'b1;
            dec_in_byte  = bytes[23 - 8*i -: 8];
            @(negedge clk);
            if (i < n-1)
                chk(!dec_out_valid, "R7 no early result", dec_out_valid, 0);
            else begin
                chk(dec_out_valid, req, dec_out_valid, 1);
                chk(dec_out_error == exp_err, req, dec_out_error, exp_err);
                chk(dec_out_value == exp_val, req, dec_out_value, exp_val);
            end
        end
        dec_in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(enc_in_ready, "R11 ready", enc_in_ready, 1);
        chk(!enc_out_valid, "R11 enc valid", enc_out_valid, 0);
        chk(!dec_out_valid, "R11 dec valid", dec_out_valid, 0);

        for (int j = 0; j < NV; j++) begin
            enc_run(VEC[j], 1'b0);
            dec_run(VEC[j][23:0], int'(VEC[j][31:24]), 1'b0, VEC[j][47:32], "R7 decode");
        end

        // R6 stall plus ignored offer, then the encoder must still send 0xFFFF
        enc_run(VEC[9], 1'b1);
        // the ignored 0x0042 must not appear afterwards
        @(negedge clk);
        chk(!enc_out_valid, "R5 ignored value not sent", enc_out_valid, 0);

        // R8 third byte with high bits set
        dec_run(24'h808007, 3, 1'b1, 16'h0000, "R8 bit2");
        dec_run(24'h808081, 3, 1'b1, 16'h0000, "R8 bit7");
        // R9 non-minimal
        dec_run(24'h800000, 2, 1'b1, 16'h0000, "R9 zero second");
        dec_run(24'h808000, 3, 1'b1, 16'h0000, "R9 zero third");
        // R10 fresh start after error
        dec_run(24'h050000, 1, 1'b0, 16'h0005, "R10 restart");

        // R11 reset mid-sequence
        @(negedge clk);
        dec_in_valid = 1'b1;
        dec_in_byte  = 8'h81;
        @(negedge clk);
        dec_in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        dec_run(24'h090000, 1, 1'b0, 16'h0009, "R11 mid reset");

        finish_run();
    end

endmodule